// File: doc/BRIEF.md
# Global Translation Purge Issue Controller

This block runs the issue side of a global translation purge. A purge command carries a virtual address, a purge size and a remap flag. The address keeps its region selector in its top three bits and passes through unchanged. The size is the base-two logarithm of the purge range in bytes. The block accepts one command at a time. It checks the privilege level and the virtualization bit that were captured with the command, and it rejects a command that is not the last one in its instruction group.

For an accepted command, the block waits until the store buffer reports empty. It then puts the purge on the domain broadcast for one cycle and, in the same cycle, sends a local purge request to its own translation cache. After that it collects one acknowledgement from every remote processor. The remap flag travels with the broadcast so that remote processors can repair their advanced-load tables. The block reports completion, or a fault with a code, for one cycle. One cycle after a successful completion it pulses a separate serialize-complete output.

The state machine has six states. IDLE accepts a command and moves to CHECK. CHECK moves to DONE on a fault and to DRAIN otherwise. DRAIN moves to BCAST once the store buffer is empty. BCAST moves to WAIT_ACK unconditionally. WAIT_ACK moves to DONE once every remote has acknowledged. DONE returns to IDLE.

Top module: `gpurge_issue_ctrl`

## Requirements
- R1: `cmd_ready_o` is high only in IDLE. A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. While the block is busy, a waiting command stays held off and is taken once the block returns to IDLE.
- R2: A command captured with `cur_priv_i` not equal to 0, or with `virt_mode_i` equal to 1, completes with `fault_o`=1 and `fault_code_o`=1. It produces no broadcast and no local purge. This check takes priority over R3.
- R3: A command that passes R2 but was captured with `cmd_last_i`=0 completes with `fault_o`=1 and `fault_code_o`=2. It produces no broadcast and no local purge.
- R4: For a command that passes both checks, `bc_valid_o` pulses for one cycle. The pulse comes in the cycle after the first DRAIN cycle in which `sb_empty_i` is sampled high, and never earlier.
- R5: During the broadcast pulse, `bc_vaddr_o`, `bc_size_o` and `bc_remap_o` equal the captured address, size and remap flag. `bc_remap_o`=1 marks a purge caused by a page remapping.
- R6: `lp_valid_o` pulses in the same cycle as `bc_valid_o`, with `lp_vaddr_o` and `lp_size_o` equal to the captured address and size.
- R7: A successful `done_o` is raised only once every bit of `ack_i` has been seen high at least once during WAIT_ACK. Acknowledgements outside WAIT_ACK are ignored, and a repeated acknowledgement has no further effect.
- R8: `ser_done_o` pulses for exactly one cycle, in the cycle after a `done_o` without fault. It never follows a faulted completion.
- R9: No second broadcast occurs before the `done_o` of the current purge.
- R10: During and right after reset, `cmd_ready_o`=1 and every pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Purge command present |
| cmd_ready_o | output | 1 | Block can take a command |
| cmd_vaddr_i | input | 64 | Purge address; region selector in bits 63:61 |
| cmd_size_i | input | 6 | Log2 of the purge range in bytes |
| cmd_remap_i | input | 1 | 1 selects the remap variant |
| cmd_last_i | input | 1 | 1 when the command ends its instruction group |
| cur_priv_i | input | 2 | Current privilege level; 0 is the most privileged |
| virt_mode_i | input | 1 | Virtualization status bit |
| sb_empty_i | input | 1 | Store buffer empty; earlier data accesses are visible |
| bc_valid_o | output | 1 | Broadcast transaction pulse |
| bc_vaddr_o | output | 64 | Broadcast address |
| bc_size_o | output | 6 | Broadcast size |
| bc_remap_o | output | 1 | Broadcast remap marker |
| ack_i | input | N_REMOTE | One acknowledgement pulse line per remote processor |
| lp_valid_o | output | 1 | Local translation cache purge pulse |
| lp_vaddr_o | output | 64 | Local purge address |
| lp_size_o | output | 6 | Local purge size |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Completion is a fault |
| fault_code_o | output | 2 | 0 none, 1 privilege/virtualization, 2 not last in group |
| ser_done_o | output | 1 | Serialize-complete pulse |

## Verification
Counting from the edge that takes a command, CHECK is one cycle later. A fault shows on `done_o` two cycles after that edge. A clean command reaches `bc_valid_o` and `lp_valid_o` one cycle after the first DRAIN cycle with the store buffer empty, which is three cycles after the edge when the buffer is already empty. `done_o` follows one cycle after the WAIT_ACK cycle in which the last missing acknowledgement arrives, and `ser_done_o` follows `done_o` by one cycle. The bench steps a behavioural model at every rising edge on the same inputs. Five nanoseconds later it compares every output against the model, so each result is checked in exactly the cycle it is due, including stray acknowledgements sent during DRAIN and a second command held off while a purge is in flight.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
    localparam int ADDR_W = 64;
    localparam int SIZE_W = 6;
    localparam int PRIV_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_DRAIN,
        ST_BCAST,
        ST_WAIT_ACK,
        ST_DONE
    } gpi_state_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_PRIV  = 2'd1,
        FLT_GROUP = 2'd2
    } gpi_fault_e;

    typedef struct packed {
        logic [ADDR_W-1:0] vaddr;
        logic [SIZE_W-1:0] size;
        logic              remap;
        logic              last;
        logic [PRIV_W-1:0] priv;
        logic              vm;
    } gpi_cmd_t;
endpackage

// File: rtl/gpi_cmd_reg.sv
module gpi_cmd_reg
    import gpi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_i,
    input  gpi_cmd_t cmd_i,
    output gpi_cmd_t cmd_o
);
    gpi_cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (load_i) begin
            cmd_q <= cmd_i;
        end
    end

    assign cmd_o = cmd_q;

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cmd_o));
endmodule

// File: rtl/gpi_perm_check.sv
module gpi_perm_check
    import gpi_pkg::*;
(
    input  gpi_cmd_t   cmd_i,
    output gpi_fault_e fault_o
);
    always_comb begin
        if (cmd_i.priv != '0 || cmd_i.vm) begin
            fault_o = FLT_PRIV;
        end else if (!cmd_i.last) begin
            fault_o = FLT_GROUP;
        end else begin
            fault_o = FLT_NONE;
        end
    end
endmodule

// File: rtl/gpi_ack_tracker.sv
module gpi_ack_tracker #(
    parameter int N_REMOTE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                en_i,
    input  logic [N_REMOTE-1:0] ack_i,
    output logic [N_REMOTE-1:0] mask_o,
    output logic                all_o
);
    logic [N_REMOTE-1:0] mask_q;
    logic [N_REMOTE-1:0] mask_d;
    logic [N_REMOTE-1:0] ack_gated;

    genvar g;
    generate
        for (g = 0; g < N_REMOTE; g++) begin : g_lane
            assign ack_gated[g] = en_i & ack_i[g];
        end
    endgenerate

    assign mask_d = mask_q | ack_gated;
    assign all_o  = &mask_d;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q;

    // R7
    mask_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((mask_o & $past(mask_o)) == $past(mask_o)));

    // R7
    no_ack_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> (mask_o == $past(mask_o)));
endmodule

// File: rtl/gpurge_issue_ctrl.sv
module gpurge_issue_ctrl
    import gpi_pkg::*;
#(
    parameter int N_REMOTE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid_i,
    output logic                cmd_ready_o,
    input  logic [63:0]         cmd_vaddr_i,
    input  logic [5:0]          cmd_size_i,
    input  logic                cmd_remap_i,
    input  logic                cmd_last_i,
    input  logic [1:0]          cur_priv_i,
    input  logic                virt_mode_i,
    input  logic                sb_empty_i,
    output logic                bc_valid_o,
    output logic [63:0]         bc_vaddr_o,
    output logic [5:0]          bc_size_o,
    output logic                bc_remap_o,
    input  logic [N_REMOTE-1:0] ack_i,
    output logic                lp_valid_o,
    output logic [63:0]         lp_vaddr_o,
    output logic [5:0]          lp_size_o,
    output logic                done_o,
    output logic                fault_o,
    output logic [1:0]          fault_code_o,
    output logic                ser_done_o
);
    gpi_state_e          state_q, state_d;
    gpi_fault_e          fault_q, chk_fault;
    gpi_cmd_t            cmd_in, cmd_cur;
    logic                take_cmd;
    logic                acks_all;
    logic [N_REMOTE-1:0] ack_mask;
    logic                ser_q;

    assign cmd_in.vaddr = cmd_vaddr_i;
    assign cmd_in.size  = cmd_size_i;
    assign cmd_in.remap = cmd_remap_i;
    assign cmd_in.last  = cmd_last_i;
    assign cmd_in.priv  = cur_priv_i;
    assign cmd_in.vm    = virt_mode_i;

    assign take_cmd = (state_q == ST_IDLE) && cmd_valid_i;

    gpi_cmd_reg u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (take_cmd),
        .cmd_i  (cmd_in),
        .cmd_o  (cmd_cur)
    );

    gpi_perm_check u_perm (
        .cmd_i   (cmd_cur),
        .fault_o (chk_fault)
    );

    gpi_ack_tracker #(.N_REMOTE(N_REMOTE)) u_acks (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_q == ST_BCAST),
        .en_i   (state_q == ST_WAIT_ACK),
        .ack_i  (ack_i),
        .mask_o (ack_mask),
        .all_o  (acks_all)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fault_q <= FLT_NONE;
            ser_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ser_q   <= (state_q == ST_DONE) && (fault_q == FLT_NONE);
            if (state_q == ST_CHECK) begin
                fault_q <= chk_fault;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_valid_i) state_d = ST_CHECK;
            ST_CHECK:    state_d = (chk_fault != FLT_NONE) ? ST_DONE : ST_DRAIN;
            ST_DRAIN:    if (sb_empty_i) state_d = ST_BCAST;
            ST_BCAST:    state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: if (acks_all) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready_o  = 1'b0;
        bc_valid_o   = 1'b0;
        lp_valid_o   = 1'b0;
        done_o       = 1'b0;
        fault_o      = 1'b0;
        fault_code_o = FLT_NONE;
        bc_vaddr_o   = '0;
        bc_size_o    = '0;
        bc_remap_o   = 1'b0;
        lp_vaddr_o   = '0;
        lp_size_o    = '0;
        unique case (state_q)
            ST_IDLE:  cmd_ready_o = 1'b1;
            ST_BCAST: begin
                bc_valid_o = 1'b1;
                bc_vaddr_o = cmd_cur.vaddr;
                bc_size_o  = cmd_cur.size;
                bc_remap_o = cmd_cur.remap;
                lp_valid_o = 1'b1;
                lp_vaddr_o = cmd_cur.vaddr;
                lp_size_o  = cmd_cur.size;
            end
            ST_DONE: begin
                done_o       = 1'b1;
                fault_o      = (fault_q != FLT_NONE);
                fault_code_o = fault_q;
            end
            default: ;
        endcase
    end

    assign ser_done_o = ser_q;

    // R1
    busy_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

    // R4
    drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid_o |-> $past(sb_empty_i));

    // R2
    fault_skips_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> !$past(ack_mask != '0 && bc_valid_o));

    // R8
    serialize_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_done_o |-> $past(done_o && !fault_o));

    // R9
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid_o |=> !bc_valid_o);

    // R7
    done_needs_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fault_o) |-> $past(acks_all));
endmodule

// File: tb/gpurge_issue_ctrl_bench.sv
module gpurge_issue_ctrl_bench;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [63:0]  cmd_vaddr = '0;
    logic [5:0]   cmd_size = '0;
    logic         cmd_remap = 1'b0;
    logic         cmd_last = 1'b1;
    logic [1:0]   cur_priv = '0;
    logic         virt_mode = 1'b0;
    logic         sb_empty = 1'b1;
    logic [N-1:0] ack_auto = '0;
    logic [N-1:0] ack_stray = '0;
    logic [N-1:0] ack;
    logic         cmd_ready, bc_valid, bc_remap, lp_valid, done, fault, ser_done;
    logic [63:0]  bc_vaddr, lp_vaddr;
    logic [5:0]   bc_size, lp_size;
    logic [1:0]   fault_code;

    assign ack = ack_auto | ack_stray;

    always #10 clk = ~clk;

    gpurge_issue_ctrl #(.N_REMOTE(N)) u_gpurge_issue_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
        .cmd_vaddr_i(cmd_vaddr), .cmd_size_i(cmd_size),
        .cmd_remap_i(cmd_remap), .cmd_last_i(cmd_last),
        .cur_priv_i(cur_priv), .virt_mode_i(virt_mode),
        .sb_empty_i(sb_empty),
        .bc_valid_o(bc_valid), .bc_vaddr_o(bc_vaddr),
        .bc_size_o(bc_size), .bc_remap_o(bc_remap),
        .ack_i(ack),
        .lp_valid_o(lp_valid), .lp_vaddr_o(lp_vaddr), .lp_size_o(lp_size),
        .done_o(done), .fault_o(fault), .fault_code_o(fault_code),
        .ser_done_o(ser_done)
    );

    int n_chk = 0;
    int n_bad = 0;
    int inflight = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int           ph = 0;      // 0 idle 1 check 2 drain 3 bcast 4 wait 5 done
    logic [63:0]  m_addr = '0;
    logic [5:0]   m_size = '0;
    logic         m_remap = 0, m_last = 0, m_vm = 0;
    logic [1:0]   m_priv = '0;
    int           m_flt = 0;
    logic [N-1:0] got = '0;
    bit           m_ser = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; m_flt = 0; got = '0; m_ser = 0; inflight = 0;
        end else begin
            m_ser = (ph == 5) && (m_flt == 0);
            case (ph)
                0: if (cmd_valid) begin
                    m_addr = cmd_vaddr; m_size = cmd_size; m_remap = cmd_remap;
                    m_last = cmd_last; m_priv = cur_priv; m_vm = virt_mode;
                    ph = 1;
                end
                1: begin
                    if (m_priv != 0 || m_vm) m_flt = 1;
                    else if (!m_last)        m_flt = 2;
                    else                     m_flt = 0;
                    ph = (m_flt != 0) ? 5 : 2;
                end
                2: if (sb_empty) ph = 3;
                3: begin got = '0; ph = 4; end
                4: begin got = got | ack; if (&got) ph = 5; end
                default: ph = 0;
            endcase
        end
        #5;
        chk("R1 cmd_ready", cmd_ready, ph == 0);
        chk("R4 bc_valid", bc_valid, ph == 3);
        chk("R6 lp_valid", lp_valid, ph == 3);
        if (ph == 3) begin
            chk("R5 bc_vaddr", bc_vaddr, m_addr);
            chk("R5 bc_size", bc_size, m_size);
            chk("R5 bc_remap", bc_remap, m_remap);
            chk("R6 lp_vaddr", lp_vaddr, m_addr);
            chk("R6 lp_size", lp_size, m_size);
        end
        chk("R7 done", done, ph == 5);
        chk("R2 R3 fault", fault, (ph == 5) && (m_flt != 0));
        chk("R2 R3 fault_code", fault_code, (ph == 5) ? m_flt : 0);
        chk("R8 ser_done", ser_done, m_ser);
        if (bc_valid) inflight++;
        chk("R9 inflight", inflight <= 1, 1);
        if (done) inflight = 0;
    end

    // remote acknowledgement responder
    int dly [N] = '{1, 2, 3, 4};
    int cnt [N] = '{0, 0, 0, 0};
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            ack_auto[i] <= 1'b0;
            if (cnt[i] > 0) begin
                cnt[i] = cnt[i] - 1;
                if (cnt[i] == 0) ack_auto[i] <= 1'b1;
            end
        end
        if (bc_valid) begin
            for (int i = 0; i < N; i++) cnt[i] = dly[i];
        end
    end

    task automatic issue(input logic [63:0] a, input logic [5:0] s, input logic rm,
                         input logic last, input logic [1:0] pv, input logic vm);
        @(negedge clk);
        cmd_valid = 1; cmd_vaddr = a; cmd_size = s; cmd_remap = rm;
        cmd_last = last; cur_priv = pv; virt_mode = vm;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic idle_wait();
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 ready in reset", cmd_ready, 1);
        chk("R10 pulses in reset", {bc_valid, lp_valid, done, fault, ser_done}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R10 ready after reset", cmd_ready, 1);

        // clean purge, buffer already empty
        issue(64'hA000_0000_1234_5000, 6'd12, 0, 1, 0, 0);
        idle_wait();

        // remap variant with a drain delay
        sb_empty = 0;
        issue(64'h2000_0000_0040_0000, 6'd22, 1, 1, 0, 0);
        repeat (4) @(negedge clk);
        ack_stray = '1;           // R7 stray acks in DRAIN are ignored
        @(negedge clk);
        ack_stray = '0;
        repeat (2) @(negedge clk);
        sb_empty = 1;
        idle_wait();

        // privilege fault R2
        issue(64'h1, 6'd4, 0, 1, 2'd3, 0);
        idle_wait();
        // virtualization fault R2
        issue(64'h2, 6'd4, 0, 1, 0, 1);
        idle_wait();
        // not last in group R3
        issue(64'h3, 6'd4, 1, 0, 0, 0);
        idle_wait();
        // both faults, privilege wins R2
        issue(64'h4, 6'd4, 0, 0, 2'd1, 0);
        idle_wait();

        // back-to-back: second command held off R1, reverse ack order R7
        dly = '{5, 3, 2, 1};
        fork
            begin
                issue(64'hE000_0000_0000_1000, 6'd13, 0, 1, 0, 0);
                issue(64'h6000_0000_0000_2000, 6'd30, 1, 1, 0, 0);
            end
            begin
                repeat (6) @(negedge clk);
                ack_stray = 4'b0001;  // R7 duplicate ack for remote 0
                @(negedge clk);
                ack_stray = '0;
            end
        join
        idle_wait();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired before the run completed");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule